// File: doc/BRIEF.md
# Octal DAC serial register interface

This block is the digital front end of an eight-channel digital-to-analog converter. A host sends 16-bit frames over a three-wire serial link: a frame-select line (active low), a serial clock, and a data line. Each complete frame either writes a 12-bit code into one of eight channel input registers, or sets the reference-mode bits for the two groups of four channels. The link is sampled by a faster system clock. All three serial inputs and the load strobe pass through synchronizer flops before any decision is made.

The design holds two registers per channel. The input registers receive serial writes. The DAC registers drive the converters. An active-low load input copies every input register into its DAC register, so all eight outputs can change on the same cycle. If the load input is held low permanently, each completed write passes straight through to the converter.

A frame that loses its frame-select before the sixteenth falling clock edge is dropped. A flag reports when the serial receiver is enabled; this flag stands in for the power state of the input pads.

Top module: `octal_dac_front`

## Requirements
- R1: After reset, every DAC output word and every reference bit reads 0, and `rx_active` reads 0.
- R2: A complete frame is received MSB first, and `sdin` is taken on each falling edge of `sclk`. In a data frame, bit 15 is 0, bits 14:12 give the channel (0 selects the word at `dac_word[11:0]` … 7 selects `dac_word[95:84]`), and bits 11:0 are the code. The frame writes the code into that channel's input register only.
- R3: While `load_n` stays high, no DAC output word changes, whatever frames arrive.
- R4: Driving `load_n` low copies all eight input registers into the DAC outputs together.
- R5: With `load_n` held low, a completed data frame appears on `dac_word` within 6 system clocks of the sixteenth falling `sclk` edge.
- R6: If `frame_n` rises before the sixteenth falling edge, the frame is discarded. No input register and no reference bit changes.
- R7: In a control frame, bit 15 is 1. Its bits 3:0 set `ref_low_buf`, `ref_high_buf`, `ref_low_vdd` and `ref_high_vdd`, in that order from bit 0. A control frame leaves every channel input register unchanged.
- R8: The frame is applied on the sixteenth falling edge. Further `sclk` falling edges before `frame_n` rises are ignored.
- R9: `rx_active` goes high within 4 system clocks after `frame_n` falls. It goes low within 4 system clocks after `frame_n` rises.
- R10: Each high phase and each low phase of `sclk` must last at least two system clock periods; under that condition every edge is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low transfer of input registers to DAC registers |
| dac_word | output | 96 | Eight 12-bit DAC register values; channel n at bits 12n+11:12n |
| ref_low_buf | output | 1 | Buffer-mode bit for channels 0-3 |
| ref_low_vdd | output | 1 | Supply-as-reference bit for channels 0-3 |
| ref_high_buf | output | 1 | Buffer-mode bit for channels 4-7 |
| ref_high_vdd | output | 1 | Supply-as-reference bit for channels 4-7 |
| rx_active | output | 1 | Serial receiver enabled (frame in progress) |

## Verification
A wrong bit counter or a bad shift direction shows at the very next load pulse: a code lands in the wrong channel, appears shifted, or appears after an aborted frame. A stale input register stays hidden while `load_n` is high. For that reason the bench follows every kind of frame with a load pulse, or runs with the load held low, and compares all eight words within a few system clocks. The reference bits and `rx_active` are visible at once, so a fault in control decode or framing shows within the same frame.

// File: rtl/octal_dac_front.sv
module octal_dac_front #(
  parameter int SYNC_STAGES = 2,
  parameter int DW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic sclk,
  input  logic sdin,
  input  logic load_n,
  output logic [8*DW-1:0] dac_word,
  output logic ref_low_buf,
  output logic ref_low_vdd,
  output logic ref_high_buf,
  output logic ref_high_vdd,
  output logic rx_active
);
  localparam int NCH = 8;
  localparam int FW = 16;
  localparam int CW = $clog2(FW + 1);

  logic [SYNC_STAGES-1:0] fr_q, ck_q, d_q, ld_q;
  logic fr_s, ck_s, d_s, ld_s;
  logic fr_prev, ck_prev, active, fall, commit;
  logic [CW-1:0] cnt;
  logic [FW-1:0] shreg, word_next;
  logic [DW-1:0] in_reg [NCH];
  logic [DW-1:0] dac_reg [NCH];
  logic [NCH*DW-1:0] in_flat;

  assign fr_s = fr_q[SYNC_STAGES-1];
  assign ck_s = ck_q[SYNC_STAGES-1];
  assign d_s  = d_q[SYNC_STAGES-1];
  assign ld_s = ld_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '1;
      ck_q <= '1;
      d_q  <= '0;
      ld_q <= '1;
    end else begin
      fr_q <= {fr_q[SYNC_STAGES-2:0], frame_n};
      ck_q <= {ck_q[SYNC_STAGES-2:0], sclk};
      d_q  <= {d_q[SYNC_STAGES-2:0], sdin};
      ld_q <= {ld_q[SYNC_STAGES-2:0], load_n};
    end
  end

  assign fall      = ck_prev & ~ck_s;
  assign word_next = {shreg[FW-2:0], d_s};
  assign commit    = active & ~fr_s & ~fr_prev & fall & (cnt == CW'(FW - 1));
  assign rx_active = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_prev <= 1'b1;
      ck_prev <= 1'b1;
      active  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
    end else begin
      fr_prev <= fr_s;
      ck_prev <= ck_s;
      if (fr_s) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (fr_prev) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && fall && cnt != CW'(FW)) begin
        shreg <= word_next;
        cnt   <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_reg[i]  <= '0;
        dac_reg[i] <= '0;
      end
      {ref_high_vdd, ref_low_vdd, ref_high_buf, ref_low_buf} <= '0;
    end else begin
      if (commit && !word_next[15])
        in_reg[word_next[14:12]] <= word_next[11 -: DW];
      if (commit && word_next[15])
        {ref_high_vdd, ref_low_vdd, ref_high_buf, ref_low_buf} <= word_next[3:0];
      if (!ld_s)
        for (int i = 0; i < NCH; i++) dac_reg[i] <= in_reg[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign dac_word[g*DW +: DW] = dac_reg[g];
    assign in_flat[g*DW +: DW]  = in_reg[g];
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_word == '0 && !rx_active));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(dac_word));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> dac_word == $past(in_flat));
  assert_nocommit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(in_flat));
  assert_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word_next[15]) |=> $stable(in_flat));
  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FW));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fr_s |=> !rx_active);
endmodule

// File: tb/octal_dac_front_test.sv
module octal_dac_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 3;

  logic clk = 0, rst_n = 0, frame_n = 1, sclk = 1, sdin = 0, load_n = 1;
  logic [95:0] dac_word;
  logic ref_low_buf, ref_low_vdd, ref_high_buf, ref_high_vdd, rx_active;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] exp_in [8];
  logic [11:0] exp_dac [8];
  logic [3:0] exp_ref;
  bit load_held;

  octal_dac_front uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdin(sdin),
    .load_n(load_n), .dac_word(dac_word), .ref_low_buf(ref_low_buf),
    .ref_low_vdd(ref_low_vdd), .ref_high_buf(ref_high_buf),
    .ref_high_vdd(ref_high_vdd), .rx_active(rx_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] ref_now();
    return {ref_high_vdd, ref_low_vdd, ref_high_buf, ref_low_buf};
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < 8; c++) check(req, dac_word[c*12 +: 12], exp_dac[c]);
    check({req, " R7 refs"}, ref_now(), exp_ref);
  endtask

  function automatic void model_frame(input logic [15:0] w);
    if (w[15]) exp_ref = w[3:0];
    else exp_in[w[14:12]] = w[11:0];
    if (load_held) for (int c = 0; c < 8; c++) exp_dac[c] = exp_in[c];
  endfunction

  // nbits < 16 aborts; extra adds falling edges after the 16th
  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    frame_n = 0;
    wait_clk(PH + 1);
    check("R9 active", rx_active, 1);
    for (int b = 0; b < nbits + extra; b++) begin
      sdin = (b < 16) ? w[15 - b] : ~w[0];
      sclk = 1;
      wait_clk(PH);
      sclk = 0;
      wait_clk(PH);
    end
    sclk = 1;
    wait_clk(2);
    frame_n = 1;
    wait_clk(PH + 1);
    check("R9 idle", rx_active, 0);
    if (nbits >= 16) model_frame(w);
  endtask

  task automatic pulse_load();
    load_n = 0;
    wait_clk(4);
    if (!load_held) load_n = 1;
    wait_clk(4);
    for (int c = 0; c < 8; c++) exp_dac[c] = exp_in[c];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(2024);
    for (int c = 0; c < 8; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    exp_ref = 0;
    load_held = 0;
    wait_clk(3);
    check("R1 rx_active", rx_active, 0);
    check_all("R1 reset");
    rst_n = 1;
    wait_clk(3);
    check_all("R1 after release");

    send(16'h3ABC, 16, 0);
    check_all("R3 held while load high");
    pulse_load();
    check_all("R2 R4 channel 3 write");

    send(16'h7123, 16, 0);
    send(16'h0FFF, 16, 0);
    check_all("R3 two writes pending");
    pulse_load();
    check_all("R4 simultaneous update");

    send(16'h5555, 9, 0);
    send(16'h5AAA, 15, 0);
    pulse_load();
    check_all("R6 aborted frames");

    send(16'h800F, 16, 0);
    pulse_load();
    check_all("R7 control frame");
    send(16'h8005, 16, 0);
    check_all("R7 control pattern 5");

    send(16'h2456, 16, 5);
    pulse_load();
    check_all("R8 extra edges ignored");

    load_held = 1;
    load_n = 0;
    wait_clk(4);
    send(16'h6789, 16, 0);
    check_all("R5 load held low");

    for (int it = 0; it < 60; it++) begin
      int kind;
      logic [15:0] w;
      kind = $urandom_range(0, 9);
      w = 16'($urandom);
      if (it == 30) begin load_held = 0; load_n = 1; wait_clk(4); end
      if (kind < 6) begin w[15] = 0; send(w, 16, $urandom_range(0, 2)); end
      else if (kind == 6) send(w, $urandom_range(1, 15), 0);
      else if (kind == 7) begin w[15] = 1; send(w, 16, 0); end
      else pulse_load();
      check_all(load_held ? "R5 R10 random" : "R2 R3 R10 random");
    end
    pulse_load();
    check_all("R4 final load");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule